// File: doc/BRIEF.md
# Integer Register File with Multiply/Divide Result Pair

This block is the integer operand store of a 32-bit load-store core. Every arithmetic and logical operation takes its operands from registers, so the file has two combinational read ports. Each port is addressed by one of the two source-register fields of the instruction. A single synchronous write port, addressed by a destination index, stores results. Decode supplies that index: it is the rd field for register-form instructions and the rt field for immediate-form instructions.

Entry 0 is fixed at zero. Writes aimed at it are dropped. When a read hits the entry being written in the same cycle, the read port returns the incoming data instead of the stale copy.

A separate 32-bit HI/LO pair sits beside the main array and receives multiply and divide results. Each half has its own write enable and its own output. The pair may be loaded in the same cycle as an array write. A synchronous active-high reset clears the whole file, including HI and LO.

Top module: `regbank_top`

## Requirements
- R1: In the cycle after a reset cycle (rst high at a rising edge), every array entry read on either port is zero, and hiOut and loOut are zero.
- R2: A write with wrEn high and a nonzero wrAddr at a rising edge makes wrData readable at that index on both read ports from the next cycle on.
- R3: Reading index 0 on either port always returns zero, even after a write of a nonzero value to index 0.
- R4: With wrEn low at a rising edge, no array entry changes, whatever wrAddr and wrData hold.
- R5: When wrEn is high, wrAddr is nonzero and a read address equals wrAddr, that read port returns wrData combinationally in the same cycle.
- R6: When wrEn is high with wrAddr equal to 0, a read port addressed to 0 returns zero and not wrData.
- R7: hiOut takes hiWrData one cycle after hiWrEn is high at a rising edge, and otherwise holds its value. loOut behaves the same way with loWrEn and loWrData, independently of HI.
- R8: HI, LO and an array entry can all be written at the same rising edge, and each takes its own data.
- R9: The two read ports select independently, so different addresses on the two ports return the two distinct stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rdAddrA | input | 5 | First source index |
| rdAddrB | input | 5 | Second source index |
| rdDataA | output | 32 | Operand from first source index |
| rdDataB | output | 32 | Operand from second source index |
| wrEn | input | 1 | Array write enable |
| wrAddr | input | 5 | Destination index |
| wrData | input | 32 | Array write data |
| hiWrEn | input | 1 | HI write enable |
| hiWrData | input | 32 | HI write data |
| loWrEn | input | 1 | LO write enable |
| loWrData | input | 32 | LO write data |
| hiOut | output | 32 | Stored HI value |
| loOut | output | 32 | Stored LO value |

## Verification
The bench writes a nonzero value to index 0 and then reads it back. A design that stored the value would return it instead of zero. It also drives a write to index 0 while reading index 0, where a bypass that ignores the zero index would leak wrData onto the port. Same-cycle bypass is checked on both ports at once and next to a disabled write to the same index. A design without bypass returns stale data; one that bypasses without checking wrEn returns data that was never written. HI and LO are loaded one at a time and then together with an array write, which exposes shared or crossed enables.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int REG_COUNT = 32;
  localparam int WORD_W    = 32;

  // strobes from the control to the datapath
  typedef struct packed {
    logic [REG_COUNT-1:0] rowEn;
    logic                 hiEn;
    logic                 loEn;
    logic                 fwdA;
    logic                 fwdB;
  } wrStrobe_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NREG   = REG_COUNT,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              hiWrEn,
  input  logic              loWrEn,
  output wrStrobe_t         strobe
);
  logic liveWrite;

  assign liveWrite = wrEn && (wrAddr != '0);

  always_comb begin
    strobe       = '0;
    strobe.hiEn  = hiWrEn;
    strobe.loEn  = loWrEn;
    strobe.fwdA  = liveWrite && (rdAddrA == wrAddr);
    strobe.fwdB  = liveWrite && (rdAddrB == wrAddr);
    for (int i = 1; i < NREG; i++) begin
      strobe.rowEn[i] = liveWrite && (wrAddr == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int NREG   = REG_COUNT,
  parameter int DATA_W = WORD_W,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] hiWrData,
  input  logic [DATA_W-1:0] loWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] loOut
);
  logic [DATA_W-1:0] rows [NREG];

  assign rows[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : gRow
    always_ff @(posedge clk) begin
      if (rst) begin
        rows[g] <= '0;
      end else if (strobe.rowEn[g]) begin
        rows[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiOut <= '0;
      loOut <= '0;
    end else begin
      if (strobe.hiEn) hiOut <= hiWrData;
      if (strobe.loEn) loOut <= loWrData;
    end
  end

  assign rdDataA = strobe.fwdA ? wrData : rows[rdAddrA];
  assign rdDataB = strobe.fwdB ? wrData : rows[rdAddrB];
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int NREG   = REG_COUNT,
  parameter int DATA_W = WORD_W,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hiWrEn,
  input  logic [DATA_W-1:0] hiWrData,
  input  logic              loWrEn,
  input  logic [DATA_W-1:0] loWrData,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] loOut
);
  wrStrobe_t strobe;

  regbank_ctrl #(.NREG(NREG)) ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .hiWrEn(hiWrEn), .loWrEn(loWrEn), .strobe(strobe)
  );

  regbank_dp #(.NREG(NREG), .DATA_W(DATA_W)) dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrData(wrData),
    .hiWrData(hiWrData), .loWrData(loWrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .hiOut(hiOut), .loOut(loOut)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              hiWrEn,
  input logic [DATA_W-1:0] hiWrData,
  input logic              loWrEn,
  input logic [DATA_W-1:0] loWrData,
  input logic [DATA_W-1:0] hiOut,
  input logic [DATA_W-1:0] loOut
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hiOut == '0 && loOut == '0));

  assert_zero_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0) |-> (rdDataA == '0));

  assert_zero_read_b_R3: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == '0) |-> (rdDataB == '0));

  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0 && rdAddrA == wrAddr) |-> (rdDataA == wrData));

  assert_write_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=>
      ((rdAddrA != $past(wrAddr)) || (wrEn && wrAddr == rdAddrA) ||
       (rdDataA == $past(wrData))));

  assert_hi_load_R7: assert property (@(posedge clk) disable iff (rst)
    hiWrEn |=> (hiOut == $past(hiWrData)));

  assert_hi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !hiWrEn |=> $stable(hiOut));

  assert_lo_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !loWrEn |=> $stable(loOut));
endmodule

bind regbank_top regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (.*);

// File: tb/regbank_top_test.sv
module regbank_top_test;
  localparam int PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] wrData = '0, hiWrData = '0, loWrData = '0;
  logic        wrEn = 1'b0, hiWrEn = 1'b0, loWrEn = 1'b0;
  logic [31:0] rdDataA, rdDataB, hiOut, loOut;

  regbank_top uut (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] expA, expB, expHi, expLo;
  } item_t;

  item_t       sbq[$];
  logic [31:0] mdl [32];
  logic [31:0] hiM, loM;
  int          total = 0, bad = 0;
  bit          driverDone = 0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push the expected outputs, update the model
  task automatic step(string tag, logic [4:0] a, logic [4:0] b,
                      logic we, logic [4:0] wa, logic [31:0] wd,
                      logic he, logic [31:0] hd, logic le, logic [31:0] ld);
    item_t it;
    @(negedge clk);
    rdAddrA = a; rdAddrB = b; wrEn = we; wrAddr = wa; wrData = wd;
    hiWrEn = he; hiWrData = hd; loWrEn = le; loWrData = ld;
    it.tag   = tag;
    it.expA  = (a == 0) ? 32'h0 : (we && wa == a) ? wd : mdl[a];
    it.expB  = (b == 0) ? 32'h0 : (we && wa == b) ? wd : mdl[b];
    it.expHi = hiM;
    it.expLo = loM;
    sbq.push_back(it);
    if (we && wa != 0) mdl[wa] = wd;
    if (he) hiM = hd;
    if (le) loM = ld;
  endtask

  // monitor: compare outputs a quarter period after each falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        cmp(it.tag, "rdDataA", rdDataA, it.expA);
        cmp(it.tag, "rdDataB", rdDataB, it.expB);
        cmp(it.tag, "hiOut", hiOut, it.expHi);
        cmp(it.tag, "loOut", loOut, it.expLo);
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    hiM = 32'h0; loM = 32'h0;
    // dirty the file before reset so the clear is observable
    rst = 1'b0;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'hDEAD0009;
    hiWrEn = 1'b1; hiWrData = 32'h1111; loWrEn = 1'b1; loWrData = 32'h2222;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    wrEn = 1'b0; hiWrEn = 1'b0; loWrEn = 1'b0;

    // R1: everything reads zero after reset
    for (int i = 0; i < 32; i += 2)
      step("R1", 5'(i), 5'(i + 1), 0, 0, 0, 0, 0, 0, 0);

    // R2: fill entries 1..31
    for (int i = 1; i < 32; i++)
      step("R2", 0, 0, 1, 5'(i), 32'hA5000000 + 32'(i * 7), 0, 0, 0, 0);
    // R2 / R9: read back, distinct addresses on each port
    for (int i = 1; i < 32; i++)
      step("R9", 5'(i), 5'(32 - i), 0, 0, 0, 0, 0, 0, 0);

    // R3: write nonzero to entry 0 then read it on both ports
    step("R3", 3, 4, 1, 0, 32'hFFFFFFFF, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R4: disabled write leaves entry 5 unchanged
    step("R4", 6, 7, 0, 5, 32'hBAD0BAD0, 0, 0, 0, 0);
    step("R4", 5, 5, 0, 0, 0, 0, 0, 0, 0);
    // R4: disabled write to the read address is not bypassed
    step("R4", 5, 6, 0, 5, 32'h12345678, 0, 0, 0, 0);

    // R5: same-cycle bypass on both ports, then stored value
    step("R5", 7, 7, 1, 7, 32'hC0DE0007, 0, 0, 0, 0);
    step("R5", 7, 8, 1, 8, 32'hC0DE0008, 0, 0, 0, 0);
    step("R5", 8, 7, 0, 0, 0, 0, 0, 0, 0);

    // R6: write to 0 while reading 0 returns zero
    step("R6", 0, 0, 1, 0, 32'h5A5A5A5A, 0, 0, 0, 0);
    step("R6", 0, 9, 1, 0, 32'h0F0F0F0F, 0, 0, 0, 0);

    // R7: HI only, then LO only, then hold
    step("R7", 1, 2, 0, 0, 0, 1, 32'h48494849, 0, 32'hEEEEEEEE);
    step("R7", 1, 2, 0, 0, 0, 0, 32'h77777777, 1, 32'h4C4F4C4F);
    step("R7", 1, 2, 0, 0, 0, 0, 32'h99999999, 0, 32'h88888888);
    step("R7", 1, 2, 0, 0, 0, 0, 0, 0, 0);

    // R8: HI, LO and array written at one edge
    step("R8", 12, 13, 1, 12, 32'h0C0C0C0C, 1, 32'hAAAA0001, 1, 32'hBBBB0002);
    step("R8", 12, 13, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 13, 12, 0, 0, 0, 0, 0, 0, 0);

    // R1 again: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0; hiWrEn = 1'b0; loWrEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    hiM = 32'h0; loM = 32'h0;
    step("R1", 12, 31, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 7, 1, 0, 0, 0, 0, 0, 0, 0);

    @(negedge clk);
    @(negedge clk);
    driverDone = 1;
  end

  initial begin
    int cyc = 0;
    while (!driverDone && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!driverDone) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
    end
    #(PERIOD);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule